// File: doc/BRIEF.md
# Block Matrix Interleaver / Deinterleaver

This block spreads burst errors across several codewords. It holds a matrix of ROWS x COLS symbols in one single-port memory. COLS is normally the length of one FEC codeword, and ROWS is the number of codewords mixed together. Operation alternates between two whole-matrix phases:

- **Fill:** the block accepts a complete matrix of symbols in one scan order.
- **Drain:** it sends the matrix out in the other scan order.

Because the two phases never overlap, the memory is never read and written in the same cycle.

With `DEINTERLEAVE = 0` the block fills column by column and drains row by row. With `DEINTERLEAVE = 1` the two orders are swapped, so a second instance undoes the first.

Handshake and control:

- `next_din` tells the source whether the symbol on `din` is taken at the next enabled edge.
- `dout_valid` marks the cycles in which `dout` holds a drained symbol.
- `sync_in` abandons the current block and starts a new fill at row 0, column 0.
- `clken` freezes the whole block while it is low.

Top module: `block_interleaver`

## Requirements
- R1: After reset `next_din` is high, `dout_valid` is low, and the first accepted symbol goes to row 0, column 0.
- R2: With `DEINTERLEAVE = 0`, output number k of a block (counting from 0) equals input number (k mod COLS)·ROWS + floor(k / COLS) of that block.
- R3: With `DEINTERLEAVE = 1`, output number k of a block equals input number (k mod ROWS)·COLS + floor(k / ROWS) of that block.
- R4: `next_din` is high for exactly ROWS·COLS accepted symbols, then low for exactly ROWS·COLS enabled drain cycles, then high again. The memory is never written and read in the same cycle.
- R5: Read latency is one enabled cycle. After each enabled edge that issues a read, `dout_valid` is high and `dout` carries the symbol read. After any other enabled edge, `dout_valid` is low.
- R6: While `clken` is low, no symbol is taken, no read is issued, and `dout`, `dout_valid` and the scan positions hold their values. A `sync_in` pulse during such a cycle has no effect.
- R7: A value on `din` in a cycle where `next_din` is low, or where `clken` is low, is not stored and does not affect any later output.
- R8: A `sync_in` high at an enabled edge does the following:
  - The write position returns to row 0, column 0 and the block enters the fill phase.
  - Any drain in progress is abandoned, and `dout_valid` is low after that edge.
  - The symbol on `din` in that cycle is not stored.
  - `next_din` is low while `sync_in` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clken | input | 1 | Clock enable; low freezes all state |
| sync_in | input | 1 | Restart a fill at row 0, column 0 |
| din | input | SYM_W | Input symbol |
| next_din | output | 1 | The symbol on `din` is taken at the next enabled edge |
| dout | output | SYM_W | Output symbol, registered memory read data |
| dout_valid | output | 1 | `dout` holds a drained symbol |

## Verification
The assertions assume that `rst_n` is held low long enough for the first edge to see a reset state. They also assume that `clken` and `sync_in` are known at every edge; no rule is placed on how `din` behaves.

The stimulus drives inputs only at falling edges, so every edge sees settled values. It mixes long random runs, with clken gaps and rare sync pulses, with directed restarts at three points: mid-fill, on the last fill symbol, and mid-drain. It also deliberately presents symbols while `next_din` is low and sync pulses while `clken` is low. This makes the ignore and freeze rules visible in the data that comes out later.

// File: rtl/blkilv_pkg.sv
package blkilv_pkg;

  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } phase_e;

  // Number of bits needed to index n entries, never less than one.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Linear memory address of matrix cell (row, col).
  function automatic int rc_lin(input int row, input int col, input int ncols);
    return row * ncols + col;
  endfunction

endpackage

// File: rtl/blkilv_scan.sv
module blkilv_scan
  import blkilv_pkg::*;
#(
  parameter int ROWS      = 20,
  parameter int COLS      = 36,
  parameter bit COL_MAJOR = 1'b0,
  localparam int DEPTH    = ROWS * COLS,
  localparam int AW       = idx_w(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          last
);

  generate
    if (COL_MAJOR) begin : g_col
      localparam int RW = idx_w(ROWS);
      localparam int CW = idx_w(COLS);

      logic [RW-1:0] row_q;
      logic [CW-1:0] col_q;
      logic [AW-1:0] addr_q;
      logic          row_end;
      logic          col_end;

      assign row_end = (row_q == RW'(ROWS - 1));
      assign col_end = (col_q == CW'(COLS - 1));

      // Moving down a column adds COLS to a running base address, so no
      // multiplier is needed. Starting a new column reloads the base from
      // the column index.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          row_q  <= '0;
          col_q  <= '0;
          addr_q <= '0;
        end else if (clear) begin
          row_q  <= '0;
          col_q  <= '0;
          addr_q <= '0;
        end else if (step) begin
          if (row_end) begin
            row_q <= '0;
            if (col_end) begin
              col_q  <= '0;
              addr_q <= '0;
            end else begin
              col_q  <= col_q + 1'b1;
              addr_q <= AW'(col_q) + AW'(1);
            end
          end else begin
            row_q  <= row_q + 1'b1;
            addr_q <= addr_q + AW'(COLS);
          end
        end
      end

      assign addr = addr_q;
      assign last = row_end && col_end;

      // R2
      col_addr_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(addr_q) == rc_lin(int'(row_q), int'(col_q), COLS));

    end else begin : g_lin
      logic [AW-1:0] addr_q;

      assign last = (addr_q == AW'(DEPTH - 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          addr_q <= '0;
        else if (clear)
          addr_q <= '0;
        else if (step)
          addr_q <= last ? '0 : addr_q + 1'b1;
      end

      assign addr = addr_q;
    end
  endgenerate

  // R4
  scan_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(addr) < DEPTH);

endmodule

// File: rtl/blkilv_ram.sv
module blkilv_ram
  import blkilv_pkg::*;
#(
  parameter int DEPTH = 720,
  parameter int W     = 8,
  localparam int AW   = idx_w(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we)
      mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else if (en && re)
      rdata <= mem[addr];
  end

  // R4
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> !(we && re));

endmodule

// File: rtl/blkilv_ctrl.sv
module blkilv_ctrl
  import blkilv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clken,
  input  logic   sync_in,
  input  logic   wr_last,
  input  logic   rd_last,
  output phase_e phase,
  output logic   take,
  output logic   rd_fire,
  output logic   restart,
  output logic   next_din,
  output logic   dout_valid
);

  phase_e phase_q;
  logic   valid_q;
  logic   filling;

  assign filling  = (phase_q == PH_FILL);
  assign take     = clken && filling && !sync_in;
  assign rd_fire  = clken && !filling && !sync_in;
  assign restart  = clken && sync_in;
  assign next_din = filling && !sync_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FILL;
    end else if (restart) begin
      phase_q <= PH_FILL;
    end else if (take && wr_last) begin
      phase_q <= PH_DRAIN;
    end else if (rd_fire && rd_last) begin
      phase_q <= PH_FILL;
    end
  end

  // Read data is registered in the memory, so the valid flag trails the
  // read issue by one enabled edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      valid_q <= 1'b0;
    else if (clken)
      valid_q <= rd_fire;
  end

  assign phase      = phase_q;
  assign dout_valid = valid_q;

  // R4
  drain_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DRAIN) |-> !next_din);

  // R5
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> dout_valid);

  // R6
  freeze_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clken |=> ($stable(dout_valid) && $stable(phase_q)));

  // R8
  sync_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clken && sync_in) |=> (phase_q == PH_FILL && !dout_valid));

endmodule

// File: rtl/block_interleaver.sv
module block_interleaver
  import blkilv_pkg::*;
#(
  parameter int ROWS         = 20,
  parameter int COLS         = 36,
  parameter int SYM_W        = 8,
  parameter bit DEINTERLEAVE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clken,
  input  logic             sync_in,
  input  logic [SYM_W-1:0] din,
  output logic             next_din,
  output logic [SYM_W-1:0] dout,
  output logic             dout_valid
);

  localparam int DEPTH = ROWS * COLS;
  localparam int AW    = idx_w(DEPTH);

  phase_e        phase;
  logic          take;
  logic          rd_fire;
  logic          restart;
  logic          wr_last;
  logic          rd_last;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic [AW-1:0] mem_addr;

  blkilv_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clken      (clken),
    .sync_in    (sync_in),
    .wr_last    (wr_last),
    .rd_last    (rd_last),
    .phase      (phase),
    .take       (take),
    .rd_fire    (rd_fire),
    .restart    (restart),
    .next_din   (next_din),
    .dout_valid (dout_valid)
  );

  // The interleaver fills in column order and drains in row order;
  // the deinterleaver swaps them.
  blkilv_scan #(.ROWS(ROWS), .COLS(COLS), .COL_MAJOR(!DEINTERLEAVE)) u_wscan (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (restart),
    .step  (take),
    .addr  (wr_addr),
    .last  (wr_last)
  );

  blkilv_scan #(.ROWS(ROWS), .COLS(COLS), .COL_MAJOR(DEINTERLEAVE)) u_rscan (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (restart),
    .step  (rd_fire),
    .addr  (rd_addr),
    .last  (rd_last)
  );

  assign mem_addr = take ? wr_addr : rd_addr;

  blkilv_ram #(.DEPTH(DEPTH), .W(SYM_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (clken),
    .we    (take),
    .re    (rd_fire),
    .addr  (mem_addr),
    .wdata (din),
    .rdata (dout)
  );

  // R8
  sync_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clken && sync_in) |=> (wr_addr == '0 && rd_addr == '0));

  // R4
  fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wr_last) |=> (!next_din && rd_addr == '0 && phase == PH_DRAIN));

  // R4
  drain_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && rd_last) |=> (wr_addr == '0 && phase == PH_FILL));

  // R6
  freeze_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clken |=> ($stable(dout) && $stable(wr_addr) && $stable(rd_addr)));

endmodule

// File: tb/block_interleaver_tb.sv
module block_interleaver_tb;

  localparam int R = 20;
  localparam int C = 36;
  localparam int W = 8;
  localparam int N = R * C;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         clken;
  logic         sync_in;
  logic [W-1:0] din;
  logic         nd_i, nd_d, dv_i, dv_d;
  logic [W-1:0] do_i, do_d;

  always #5 clk = ~clk;

  block_interleaver #(.ROWS(R), .COLS(C), .SYM_W(W), .DEINTERLEAVE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .clken(clken), .sync_in(sync_in), .din(din),
    .next_din(nd_i), .dout(do_i), .dout_valid(dv_i));

  block_interleaver #(.ROWS(R), .COLS(C), .SYM_W(W), .DEINTERLEAVE(1'b1)) u_dut_deint (
    .clk(clk), .rst_n(rst_n), .clken(clken), .sync_in(sync_in), .din(din),
    .next_din(nd_d), .dout(do_d), .dout_valid(dv_d));

  int           vecs = 0;
  int           errs = 0;
  bit           done = 1'b0;
  string        scen = "R1";
  logic [W-1:0] blk [N];
  bit           m_drain;
  int           m_wcnt;
  int           m_rcnt;
  bit           e_valid;
  logic [W-1:0] e_di;
  logic [W-1:0] e_dd;

  // R2: interleaved output k comes from input (k mod C)*R + k/C
  function automatic int perm_i(input int k);
    return (k % C) * R + k / C;
  endfunction

  // R3: deinterleaved output k comes from input (k mod R)*C + k/R
  function automatic int perm_d(input int k);
    return (k % R) * C + k / R;
  endfunction

  function automatic logic [W-1:0] rnd();
    return W'($urandom);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, scen, act, exp, $time);
    end
  endtask

  // One cycle: drive at a falling edge, model the coming rising edge,
  // check the outputs at the next falling edge.
  task automatic cyc(input bit en, input bit sy, input logic [W-1:0] d);
    bit exp_nd;
    clken   = en;
    sync_in = sy;
    din     = d;
    #1;
    exp_nd = !m_drain && !sy;
    chk(nd_i == exp_nd, sy ? "R8" : "R4", int'(nd_i), int'(exp_nd));
    chk(nd_d == exp_nd, sy ? "R8" : "R4", int'(nd_d), int'(exp_nd));
    if (en) begin
      if (sy) begin
        m_drain = 1'b0; m_wcnt = 0; m_rcnt = 0; e_valid = 1'b0;
      end else if (!m_drain) begin
        blk[m_wcnt] = d;
        m_wcnt++;
        e_valid = 1'b0;
        if (m_wcnt == N) begin m_drain = 1'b1; m_rcnt = 0; end
      end else begin
        e_valid = 1'b1;
        e_di = blk[perm_i(m_rcnt)];
        e_dd = blk[perm_d(m_rcnt)];
        m_rcnt++;
        if (m_rcnt == N) begin m_drain = 1'b0; m_wcnt = 0; end
      end
    end
    @(negedge clk);
    // R5 valid timing; R6 hold when clken was low
    chk(dv_i == e_valid, en ? "R5" : "R6", int'(dv_i), int'(e_valid));
    chk(dv_d == e_valid, en ? "R5" : "R6", int'(dv_d), int'(e_valid));
    if (e_valid) begin
      chk(do_i == e_di, "R2", int'(do_i), int'(e_di));
      chk(do_d == e_dd, "R3", int'(do_d), int'(e_dd));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; clken = 1'b0; sync_in = 1'b0; din = '0;
    m_drain = 1'b0; m_wcnt = 0; m_rcnt = 0; e_valid = 1'b0; e_di = '0; e_dd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(nd_i == 1'b1, "R1", int'(nd_i), 1);
    chk(nd_d == 1'b1, "R1", int'(nd_d), 1);
    chk(dv_i == 1'b0, "R1", int'(dv_i), 0);
    chk(dv_d == 1'b0, "R1", int'(dv_d), 0);

    // R1, R2, R3: two full blocks at full rate from reset
    scen = "R2";
    repeat (2 * N) cyc(1'b1, 1'b0, rnd());

    // R6: clken gaps, with din changing during the gaps
    scen = "R6";
    repeat (3 * N) cyc(($urandom % 4) != 0, 1'b0, rnd());

    // R7: alternating patterns presented while draining are never stored
    scen = "R7";
    repeat (2 * N) cyc(1'b1, 1'b0, m_drain ? W'(8'hA5) : rnd());

    // R8: restart in the middle of a fill
    scen = "R8";
    while (!(!m_drain && m_wcnt == 100)) cyc(1'b1, 1'b0, rnd());
    cyc(1'b1, 1'b1, W'(8'h3C));
    repeat (2 * N) cyc(1'b1, 1'b0, rnd());
    // R8: restart on the last symbol of a fill
    while (!(!m_drain && m_wcnt == N - 1)) cyc(1'b1, 1'b0, rnd());
    cyc(1'b1, 1'b1, rnd());
    // R8: restart in the middle of a drain
    while (!(m_drain && m_rcnt == 50)) cyc(1'b1, 1'b0, rnd());
    cyc(1'b1, 1'b1, rnd());
    // R6: a sync pulse while clken is low does nothing
    repeat (30) cyc(1'b1, 1'b0, rnd());
    cyc(1'b0, 1'b1, rnd());
    repeat (2 * N + 10) cyc(1'b1, 1'b0, rnd());

    // R4: long random mix with rare restarts
    scen = "R4";
    repeat (4 * N) cyc(($urandom % 5) != 0, ($urandom % 1000) == 0, rnd());

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL R4 watchdog expired, actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule